// File: doc/BRIEF.md
# RTC Alarm Repeat-Mode Controller

This block holds four alarm registers (seconds, minutes, hours, day of month) in packed BCD. Bit 7 of each register is a mask bit. Taken together, the four mask bits choose how often the alarm interrupt fires: once a month, once a day, once an hour, once a minute, or on every second. The block has no single compare-equal rule. A masked field is a don't-care, and the mask pattern selects the repeat period by priority.

A timekeeping counter outside the block supplies the current time as four BCD bytes, laid out like the alarm registers, and a one-second tick strobe. The fields are compared on the rising edge of the tick. When the selected fields match, the block raises a one-clock interrupt pulse on the next cycle. A software-facing write port loads the registers. Seconds, minutes and hours writes whose BCD value is out of range are dropped.

Top module: `rtc_alarm_repeat`

## Requirements
- R1: Reset clears all four alarm registers to 0x00 and holds `irq` low. With cleared registers the alarm is in monthly mode and matches the time 00 day 00, 00:00:00.
- R2: A write with `wr_en` high stores `wr_data` into the register chosen by `wr_sel`. The encodings are 0 = seconds, 1 = minutes, 2 = hours, 3 = day of month. Bit 7 of each register is its mask bit.
- R3: A seconds or minutes write is accepted only if bits 6:0 form BCD 00 to 59, with tens 0 to 5 and units 0 to 9. Any other write leaves the register unchanged.
- R4: An hours write is accepted only if bits 5:0 form BCD 00 to 23. Any other write leaves the register unchanged.
- R5: A day-of-month write is always accepted. Only bits 5:0 of the day are compared, so bit 6 of the register and of `now_day` has no effect. Hours also compare bits 5:0, while seconds and minutes compare bits 6:0.
- R6: With all four masks clear (monthly), the alarm fires only when day, hour, minute and second all match.
- R7: With only the day mask set (daily), the alarm fires when hour, minute and second match, whatever the day.
- R8: With the day and hour masks set and the minute and seconds masks clear (hourly), the alarm fires when minute and second match.
- R9: With the day, hour and minute masks set and the seconds mask clear (per minute), the alarm fires when the second matches.
- R10: Every other mask combination fires the alarm on every tick.
- R11: `irq` is high for exactly one clock, in the cycle after a rising edge of `tick` whose comparison hits. A tick held high for several cycles counts once, and there is no pulse without a tick.
- R12: A register write in the same cycle as a tick edge does not affect that comparison. The old value is used, and the new value takes effect from the next tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Alarm register write strobe |
| wr_sel | input | 2 | Register select: 0 sec, 1 min, 2 hour, 3 day |
| wr_data | input | 8 | Write data: mask in bit 7, BCD value below it |
| tick | input | 1 | One-second strobe; its rising edge triggers a comparison |
| now_sec | input | 8 | Current seconds, BCD |
| now_min | input | 8 | Current minutes, BCD |
| now_hour | input | 8 | Current hours, BCD |
| now_day | input | 8 | Current day of month, BCD |
| irq | output | 1 | One-clock alarm interrupt pulse |

## Verification
A register write and a tick comparison can happen in the same clock. The bench provokes this by putting a seconds write on the tick cycle while the old seconds alarm equals `now_sec`. It expects the interrupt to follow the old value on that tick and the new value on the next one. A second overlap is a tick held high across several cycles, which must still give only one interrupt pulse.

// File: rtl/alm_pkg.sv
package alm_pkg;
    localparam int FIELD_W    = 8;
    localparam int NUM_FIELDS = 4;
    localparam int SEL_W      = $clog2(NUM_FIELDS);
    localparam int MASK_BIT   = FIELD_W - 1;

    typedef enum logic [SEL_W-1:0] {
        F_SEC  = 2'd0,
        F_MIN  = 2'd1,
        F_HOUR = 2'd2,
        F_DAY  = 2'd3
    } field_e;

    typedef enum logic [2:0] {
        RPT_MONTH  = 3'd0,
        RPT_DAY    = 3'd1,
        RPT_HOUR   = 3'd2,
        RPT_MINUTE = 3'd3,
        RPT_SECOND = 3'd4
    } rpt_e;

    // Index f holds field f (0 sec .. 3 day)
    typedef logic [NUM_FIELDS-1:0][FIELD_W-1:0] fields_t;

    // Compared value bits per field: sec/min use 6:0, hour/day use 5:0
    function automatic logic [FIELD_W-1:0] cmp_bits(input int f);
        return (f < 2) ? 8'h7F : 8'h3F;
    endfunction
endpackage

// File: rtl/alm_bcd_check.sv
module alm_bcd_check
    import alm_pkg::*;
(
    input  logic [SEL_W-1:0]   sel,
    input  logic [FIELD_W-1:0] data,
    output logic               legal
);
    logic [2:0] tens;
    logic [3:0] units;

    always_comb begin
        tens  = data[6:4];
        units = data[3:0];
        legal = 1'b0;
        unique case (field_e'(sel))
            F_SEC, F_MIN: legal = (tens <= 3'd5) && (units <= 4'd9);
            F_HOUR:       legal = (data[5:4] <= 2'd2) && (units <= 4'd9) &&
                                  !((data[5:4] == 2'd2) && (units > 4'd3));
            F_DAY:        legal = 1'b1;
            default:      legal = 1'b0;
        endcase
    end
endmodule

// File: rtl/alm_regfile.sv
module alm_regfile
    import alm_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [SEL_W-1:0]   wr_sel,
    input  logic [FIELD_W-1:0] wr_data,
    input  logic               wr_legal,
    output fields_t            regs
);
    typedef struct packed {
        fields_t r;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en && wr_legal) begin
            st_d.r[wr_sel] = wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign regs = st_q.r;

    // R3: stored seconds/minutes always legal BCD 0..59
    a_r3_sec_min_legal: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.r[F_SEC][6:4] <= 3'd5) && (st_q.r[F_SEC][3:0] <= 4'd9) &&
        (st_q.r[F_MIN][6:4] <= 3'd5) && (st_q.r[F_MIN][3:0] <= 4'd9));

    // R4: stored hours always legal BCD 0..23
    a_r4_hour_legal: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.r[F_HOUR][3:0] <= 4'd9) &&
        ({st_q.r[F_HOUR][5:4], st_q.r[F_HOUR][3:0]} <= 6'h23));

    // R3/R4: rejected write leaves register unchanged
    a_r3_reject_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_legal) |=> $stable(st_q.r));
endmodule

// File: rtl/alm_matcher.sv
module alm_matcher
    import alm_pkg::*;
(
    input  fields_t alarm,
    input  fields_t now,
    output rpt_e    mode,
    output logic    hit
);
    logic [NUM_FIELDS-1:0] eq;
    logic [NUM_FIELDS-1:0] msk;
    logic [NUM_FIELDS-1:0] care;

    for (genvar f = 0; f < NUM_FIELDS; f++) begin : g_cmp
        assign eq[f]  = ((alarm[f] ^ now[f]) & cmp_bits(f)) == '0;
        assign msk[f] = alarm[f][MASK_BIT];
    end

    always_comb begin
        care = '0;
        // Priority decode: {day,hour,min,sec} masks
        unique case ({msk[F_DAY], msk[F_HOUR], msk[F_MIN], msk[F_SEC]})
            4'b0000: begin mode = RPT_MONTH;  care = 4'b1111; end
            4'b1000: begin mode = RPT_DAY;    care = 4'b0111; end
            4'b1100: begin mode = RPT_HOUR;   care = 4'b0011; end
            4'b1110: begin mode = RPT_MINUTE; care = 4'b0001; end
            default: begin mode = RPT_SECOND; care = 4'b0000; end
        endcase
        hit = &(eq | ~care);
    end
endmodule

// File: rtl/rtc_alarm_repeat.sv
module rtc_alarm_repeat
    import alm_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [1:0]   wr_sel,
    input  logic [7:0]   wr_data,
    input  logic         tick,
    input  logic [7:0]   now_sec,
    input  logic [7:0]   now_min,
    input  logic [7:0]   now_hour,
    input  logic [7:0]   now_day,
    output logic         irq
);
    logic    wr_legal;
    fields_t alarm;
    fields_t now;
    rpt_e    mode;
    logic    hit;

    typedef struct packed {
        logic tick_prev;
        logic irq;
    } state_t;

    state_t st_d, st_q;

    assign now = {now_day, now_hour, now_min, now_sec};

    alm_bcd_check u_check (
        .sel   (wr_sel),
        .data  (wr_data),
        .legal (wr_legal)
    );

    alm_regfile u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_sel   (wr_sel),
        .wr_data  (wr_data),
        .wr_legal (wr_legal),
        .regs     (alarm)
    );

    alm_matcher u_match (
        .alarm (alarm),
        .now   (now),
        .mode  (mode),
        .hit   (hit)
    );

    always_comb begin
        st_d           = st_q;
        st_d.tick_prev = tick;
        // R12: hit uses registered alarm (pre-write value)
        st_d.irq       = tick && !st_q.tick_prev && hit;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign irq = st_q.irq;

    // R11: pulse is one clock wide
    a_r11_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

    // R11: pulse only follows a tick
    a_r11_needs_tick: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(tick));

    // R10: every-second mode fires on each tick edge
    a_r10_every_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !st_q.tick_prev && mode == RPT_SECOND) |=> irq);

    // R1: irq low right after reset
    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> !irq);
endmodule

// File: tb/rtc_alarm_repeat_bench.sv
module rtc_alarm_repeat_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_sel = 2'd0;
    logic [7:0] wr_data = 8'h00;
    logic       tick = 1'b0;
    logic [7:0] now_sec = 8'h00, now_min = 8'h00, now_hour = 8'h00, now_day = 8'h00;
    logic       irq;

    int checks = 0;
    int failures = 0;

    always #2.5 clk = ~clk;

    rtc_alarm_repeat u_rtc_alarm_repeat (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .tick(tick), .now_sec(now_sec), .now_min(now_min),
        .now_hour(now_hour), .now_day(now_day), .irq(irq)
    );

    // {alarm s,m,h,d, now s,m,h,d, expected, requirement number}
    typedef struct packed {
        logic [31:0] alm;
        logic [31:0] now;
        logic        exp;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{32'h30151205, 32'h30151205, 1'b1, 8'd6},  // R6 monthly full match
        '{32'h30151205, 32'h30151206, 1'b0, 8'd6},  // R6 day differs
        '{32'h30151205, 32'h29151205, 1'b0, 8'd6},  // R6 second differs
        '{32'h30151285, 32'h30151217, 1'b1, 8'd7},  // R7 daily, any day
        '{32'h30151285, 32'h30151305, 1'b0, 8'd7},  // R7 hour differs
        '{32'h30159285, 32'h30150722, 1'b1, 8'd8},  // R8 hourly
        '{32'h30159285, 32'h30160722, 1'b0, 8'd8},  // R8 minute differs
        '{32'h30959285, 32'h30440309, 1'b1, 8'd9},  // R9 per minute
        '{32'h30959285, 32'h31440309, 1'b0, 8'd9},  // R9 second differs
        '{32'hB0151205, 32'h01020304, 1'b1, 8'd10}, // R10 only sec mask
        '{32'h30951285, 32'h00000001, 1'b1, 8'd10}, // R10 day+min masks
        '{32'h30151245, 32'h30151205, 1'b1, 8'd5}   // R5 day bit 6 ignored
    };

    task automatic check(input logic got, input logic exp, input string tag);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s: irq=%0b expected=%0b", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [1:0] sel, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic set_now(input logic [31:0] t);
        {now_sec, now_min, now_hour, now_day} = t;
    endtask

    // One-cycle tick, returns irq sampled the cycle after
    task automatic pulse(output logic got);
        @(negedge clk); tick = 1'b1;
        @(negedge clk); tick = 1'b0; got = irq;
        @(negedge clk);
    endtask

    initial begin
        #4_000_000;
        failures++;
        $display("FAIL watchdog: run hung, expected completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic g;
        repeat (3) @(negedge clk);
        check(irq, 1'b0, "R1 irq low in reset");
        rst_n = 1'b1;
        @(negedge clk);
        check(irq, 1'b0, "R1 irq low after reset");
        set_now(32'h00000000); pulse(g);
        check(g, 1'b1, "R1 cleared regs match 00");
        set_now(32'h01000000); pulse(g);
        check(g, 1'b0, "R1 cleared regs monthly mode");

        for (int i = 0; i < NV; i++) begin
            wr(2'd0, VECS[i].alm[31:24]);
            wr(2'd1, VECS[i].alm[23:16]);
            wr(2'd2, VECS[i].alm[15:8]);
            wr(2'd3, VECS[i].alm[7:0]);
            set_now(VECS[i].now); pulse(g);
            check(g, VECS[i].exp, $sformatf("R%0d vector %0d", VECS[i].req, i));
        end

        // R2/R3: monthly alarm 12:15:30 day 05, invalid second writes dropped
        wr(2'd0, 8'h30); wr(2'd1, 8'h15); wr(2'd2, 8'h12); wr(2'd3, 8'h05);
        wr(2'd0, 8'h60); wr(2'd0, 8'h5A); wr(2'd1, 8'h7F);
        set_now(32'h30151205); pulse(g);
        check(g, 1'b1, "R3 invalid sec/min writes ignored");
        // R4: hour 24 dropped, then 23 accepted
        wr(2'd2, 8'h24);
        pulse(g);
        check(g, 1'b1, "R4 hour 24 ignored");
        wr(2'd2, 8'h23);
        pulse(g);
        check(g, 1'b0, "R4 hour 23 accepted, old 12 no longer matches");
        set_now(32'h30152305); pulse(g);
        check(g, 1'b1, "R4 hour 23 matches");
        // R2: masked valid seconds write accepted -> every-second mode
        wr(2'd0, 8'hD9);
        set_now(32'h01020304); pulse(g);
        check(g, 1'b1, "R2 mask bit stored");

        // R11: no tick -> no irq; held tick -> one pulse
        wr(2'd0, 8'h30); wr(2'd2, 8'h12);
        set_now(32'h30151205);
        repeat (3) @(negedge clk);
        check(irq, 1'b0, "R11 no irq without tick");
        @(negedge clk); tick = 1'b1;
        @(negedge clk); g = irq;
        check(g, 1'b1, "R11 held tick first cycle");
        @(negedge clk);
        check(irq, 1'b0, "R11 held tick counts once");
        @(negedge clk); tick = 1'b0;
        check(irq, 1'b0, "R11 held tick still once");
        @(negedge clk);

        // R12: write sec 31 on the tick cycle; old value 30 still used
        @(negedge clk);
        tick = 1'b1; wr_en = 1'b1; wr_sel = 2'd0; wr_data = 8'h31;
        @(negedge clk);
        tick = 1'b0; wr_en = 1'b0; g = irq;
        check(g, 1'b1, "R12 tick uses old alarm value");
        @(negedge clk);
        pulse(g);
        check(g, 1'b0, "R12 new value used on next tick");
        set_now(32'h31151205); pulse(g);
        check(g, 1'b1, "R12 new value matches");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule